// File: doc/BRIEF.md
# Peripheral-to-AHB Burst Bridge

This block connects a simple peripheral-side bus, driven by a DMA master, to an AHB-style master port. Everything runs on one clock. The peripheral bus has no way to state how many words a transfer will move. The bridge therefore handles the two directions differently.

On a read, the bridge queues one fixed four-beat incrementing AHB read burst. It buffers the returned words in a data FIFO and hands them to the peripheral master in order, each as soon as it arrives. When the peripheral transaction closes, the bridge waits for the burst to finish and then discards any words the master did not take.

On a write, each accepted word goes straight into the data FIFO while the bridge counts the beats. Only after the peripheral transaction closes does a command carrying that count enter the command FIFO. The AHB side then issues a write burst of exactly that length. Between transactions the bridge drains its internal state, so the two directions never share stale FIFO contents.

Top module: `pbus_ahb_bridge`

## Requirements
- R1: A transaction opens only on a cycle where both `p_sel` and `p_gnt` are high. Without the grant, `p_ack` stays low and no AHB transfer appears.
- R2: A read produces exactly one AHB burst of 4 beats. The first beat has HTRANS = 2'b10 (NONSEQ) and HBURST = 3'b011. Beats 2 to 4 have HTRANS = 2'b11 (SEQ), and each beat's address is 4 above the previous one. HSIZE is always 3'b010.
- R3: In a read, `p_ack` rises only when a returned word is available. Beat k of the peripheral transaction (k from 0) delivers the word read from address `p_addr + 4*k`.
- R4: Words of a read burst that the peripheral master did not consume are discarded. The next read transaction returns only its own words.
- R5: Write data is held in the data FIFO and no AHB write starts before `p_sel` falls. The burst then has as many beats as the transaction accepted, at `p_addr + 4*k`, and carries the words in the order they were accepted.
- R6: A write burst of one beat uses HBURST = 3'b000 (single). Any longer write burst uses HBURST = 3'b001 (incrementing, undefined length).
- R7: The data FIFO holds 16 words. While it is full, `p_ack` stays low for write beats. A write transaction therefore issues at most 16 AHB beats.
- R8: While HREADY is low, HTRANS, HADDR and HBURST hold their values, and no read or write word is lost or repeated.
- R9: During and after reset, HTRANS is 2'b00 (IDLE), `p_ack` is low and both FIFOs are empty.
- R10: A write transaction that accepts no beats produces no AHB transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| p_gnt | input | 1 | The DMA master owns the peripheral bus |
| p_sel | input | 1 | Transaction active; its falling edge ends the transaction |
| p_write | input | 1 | 1 = write to memory, 0 = read from memory |
| p_addr | input | AW | Start byte address of the transaction |
| p_beat | input | 1 | The master requests one data beat |
| p_wdata | input | DW | Write data for the current beat |
| p_ack | output | 1 | The current beat completes on this clock edge |
| p_rdata | output | DW | Read data for the current beat |
| htrans | output | 2 | AHB transfer type |
| haddr | output | AW | AHB address |
| hwrite | output | 1 | AHB write flag |
| hsize | output | 3 | AHB transfer size (word) |
| hburst | output | 3 | AHB burst type |
| hwdata | output | DW | AHB write data (data phase) |
| hrdata | input | DW | AHB read data |
| hready | input | 1 | AHB transfer-done / stall |

## Verification
Some faults stay hidden inside the bridge. A read flush that is lost or arrives too late leaves old words in the shared data FIFO. This shows at the ports on the first beat of the next read, which returns the previous burst's address pattern instead of its own. A write beat counter that is off by one shows as soon as the held-back command is issued, as one AHB beat too many or too few. A wrong first-beat count also flips HBURST between single and incrementing. A pipeline that mishandles stalls under HREADY shows within a few beats. Either the address step breaks, or a word is duplicated or skipped in HWDATA or on `p_rdata`. Every read and write length is therefore swept both with and without periodic HREADY stalls.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_t;

  localparam logic [2:0] HB_SINGLE = 3'b000;
  localparam logic [2:0] HB_INCR   = 3'b001;
  localparam logic [2:0] HB_INCR4  = 3'b011;
  localparam logic [2:0] HS_WORD   = 3'b010;
  localparam int         RD_BEATS  = 4;

  typedef enum logic [1:0] {
    SP_IDLE,
    SP_READ,
    SP_WRITE,
    SP_END
  } sp_state_t;
endpackage

// File: rtl/pbb_fifo.sv
module pbb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  // DEPTH is a power of two so the pointers wrap naturally
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (cnt == '0);
  assign full    = (cnt == (PW+1)'(DEPTH));
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pbb_slave_port.sv
module pbb_slave_port
  import pbb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             p_gnt,
  input  logic             p_sel,
  input  logic             p_write,
  input  logic [AW-1:0]    p_addr,
  input  logic             p_beat,
  output logic             p_ack,
  input  logic             d_empty,
  input  logic             d_full,
  output logic             d_push,
  output logic             d_pop,
  output logic             d_clr,
  input  logic             c_full,
  output logic             c_push,
  output logic [AW+LW:0]   c_din,
  input  logic             bus_busy
);
  sp_state_t      st;
  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  cnt;
  logic           go;

  assign go = p_sel && p_gnt && !c_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SP_IDLE;
      addr_q <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        SP_IDLE: if (go) begin
          addr_q <= p_addr;
          cnt    <= '0;
          st     <= p_write ? SP_WRITE : SP_READ;
        end
        SP_READ: if (!p_sel) st <= SP_END;
        SP_WRITE: begin
          if (d_push && cnt != LW'(DEPTH)) cnt <= cnt + 1'b1;
          if (!p_sel) st <= SP_END;
        end
        default: if (!bus_busy) st <= SP_IDLE;
      endcase
    end
  end

  always_comb begin
    p_ack  = p_sel && p_beat &&
             ((st == SP_READ && !d_empty) || (st == SP_WRITE && !d_full));
    d_pop  = p_ack && (st == SP_READ);
    d_push = p_ack && (st == SP_WRITE);
    d_clr  = (st == SP_END) && !bus_busy;
    // read: fixed-length command now; write: counted command at the end
    c_push = (st == SP_IDLE && go && !p_write) ||
             (st == SP_WRITE && !p_sel && cnt != '0);
    c_din  = (st == SP_IDLE) ? {1'b0, p_addr, LW'(RD_BEATS)}
                             : {1'b1, addr_q, cnt};
  end
endmodule

// File: rtl/pbb_ahb_master.sv
module pbb_ahb_master
  import pbb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hready,
  input  logic           c_empty,
  input  logic [AW+LW:0] c_dout,
  output logic           c_pop,
  input  logic [DW-1:0]  d_dout,
  output logic           d_pop,
  output logic           d_push,
  output logic           busy,
  output htrans_t        htrans,
  output logic [AW-1:0]  haddr,
  output logic           hwrite,
  output logic [2:0]     hburst,
  output logic [DW-1:0]  hwdata
);
  logic          c_wr;
  logic [AW-1:0] c_addr;
  logic [LW-1:0] c_len;
  logic [LW-1:0] left;
  logic          dp_rd, dp_act, ap_act;

  assign c_wr   = c_dout[AW+LW];
  assign c_addr = c_dout[AW+LW-1:LW];
  assign c_len  = c_dout[LW-1:0];
  assign ap_act = (htrans != HT_IDLE);

  always_comb begin
    c_pop  = hready && left == '0 && !c_empty;
    d_pop  = hready && ap_act && hwrite;
    d_push = hready && dp_rd;
    busy   = ap_act || dp_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      htrans <= HT_IDLE;
      haddr  <= '0;
      hwrite <= 1'b0;
      hburst <= HB_SINGLE;
      hwdata <= '0;
      left   <= '0;
      dp_rd  <= 1'b0;
      dp_act <= 1'b0;
    end else if (hready) begin
      dp_act <= ap_act;
      dp_rd  <= ap_act && !hwrite;
      if (ap_act && hwrite) hwdata <= d_dout;
      if (left != '0) begin
        htrans <= HT_SEQ;
        haddr  <= haddr + AW'(4);
        left   <= left - 1'b1;
      end else if (!c_empty) begin
        htrans <= HT_NONSEQ;
        haddr  <= c_addr;
        hwrite <= c_wr;
        hburst <= !c_wr ? HB_INCR4 : (c_len == LW'(1) ? HB_SINGLE : HB_INCR);
        left   <= c_len - 1'b1;
      end else begin
        htrans <= HT_IDLE;
      end
    end
  end
endmodule

// File: rtl/pbus_ahb_bridge.sv
module pbus_ahb_bridge
  import pbb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int CDEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p_gnt,
  input  logic          p_sel,
  input  logic          p_write,
  input  logic [AW-1:0] p_addr,
  input  logic          p_beat,
  input  logic [DW-1:0] p_wdata,
  output logic          p_ack,
  output logic [DW-1:0] p_rdata,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int CW = 1 + AW + LW;

  logic          c_push, c_pop, c_empty, c_full;
  logic [CW-1:0] c_din, c_dout;
  logic          s_push, s_pop, m_push, m_pop;
  logic          d_push, d_pop, d_clr, d_empty, d_full;
  logic [DW-1:0] d_din, d_dout;
  logic          m_busy;
  htrans_t       ht;

  assign d_push  = s_push | m_push;
  assign d_pop   = s_pop | m_pop;
  assign d_din   = s_push ? p_wdata : hrdata;
  assign p_rdata = d_dout;
  assign htrans  = ht;
  assign hsize   = HS_WORD;

  pbb_fifo #(.W(CW), .DEPTH(CDEPTH)) u_cmd (
    .clk(clk), .rst(rst), .clr(1'b0), .push(c_push), .din(c_din),
    .pop(c_pop), .dout(c_dout), .empty(c_empty), .full(c_full)
  );

  pbb_fifo #(.W(DW), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .clr(d_clr), .push(d_push), .din(d_din),
    .pop(d_pop), .dout(d_dout), .empty(d_empty), .full(d_full)
  );

  pbb_slave_port #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_slv (
    .clk(clk), .rst(rst), .p_gnt(p_gnt), .p_sel(p_sel), .p_write(p_write),
    .p_addr(p_addr), .p_beat(p_beat), .p_ack(p_ack),
    .d_empty(d_empty), .d_full(d_full), .d_push(s_push), .d_pop(s_pop),
    .d_clr(d_clr), .c_full(c_full), .c_push(c_push), .c_din(c_din),
    .bus_busy(m_busy || !c_empty)
  );

  pbb_ahb_master #(.AW(AW), .DW(DW), .LW(LW)) u_mst (
    .clk(clk), .rst(rst), .hready(hready), .c_empty(c_empty),
    .c_dout(c_dout), .c_pop(c_pop), .d_dout(d_dout), .d_pop(m_pop),
    .d_push(m_push), .busy(m_busy), .htrans(ht), .haddr(haddr),
    .hwrite(hwrite), .hburst(hburst), .hwdata(hwdata)
  );
endmodule

// File: rtl/pbb_checker.sv
module pbb_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          hwrite,
  input logic [2:0]    hburst,
  input logic          hready,
  input logic          p_sel,
  input logic          p_ack,
  input logic          d_push,
  input logic          d_full,
  input logic          d_pop,
  input logic          d_empty
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hready && htrans != 2'b00) |=> ($stable(haddr) && $stable(htrans) && $stable(hburst))); // R8

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (hready && htrans != 2'b00) |=> (htrans != 2'b11 || haddr == $past(haddr) + AW'(4))); // R2

  AST_READ_INCR4: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && !hwrite) |-> (hburst == 3'b011)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    d_push |-> !d_full); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    d_pop |-> !d_empty); // R3

  AST_ACK_IN_TXN: assert property (@(posedge clk) disable iff (rst)
    p_ack |-> p_sel); // R1
endmodule

bind pbus_ahb_bridge pbb_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
  .hburst(hburst), .hready(hready), .p_sel(p_sel), .p_ack(p_ack),
  .d_push(d_push), .d_full(d_full), .d_pop(d_pop), .d_empty(d_empty)
);

// File: tb/pbus_ahb_bridge_test.sv
`timescale 1ns/1ps
module pbus_ahb_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        p_gnt = 1'b1, p_sel = 1'b0, p_write = 1'b0, p_beat = 1'b0;
  logic [31:0] p_addr = '0, p_wdata = '0;
  logic        p_ack;
  logic [31:0] p_rdata;
  logic [1:0]  htrans;
  logic [31:0] haddr, hwdata;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;

  int nchk = 0, nfail = 0;
  int stall = 0, cyc = 0;

  always #5 clk = ~clk;

  pbus_ahb_bridge uut (
    .clk(clk), .rst(rst), .p_gnt(p_gnt), .p_sel(p_sel), .p_write(p_write),
    .p_addr(p_addr), .p_beat(p_beat), .p_wdata(p_wdata), .p_ack(p_ack),
    .p_rdata(p_rdata), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C00_00C3;
  endfunction

  function automatic logic [31:0] wr_word(logic [31:0] base, int k);
    return base * 32'd7 + 32'(k) * 32'h0101_0101 + 32'h55;
  endfunction

  // AHB slave model: sample at negedge, apply just after posedge
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_wr   [64];
  logic [1:0]  log_tr   [64];
  logic [2:0]  log_bu   [64];
  int          nlog = 0;
  logic        dp_v = 1'b0, dp_w = 1'b0, pd_v = 1'b0, pd_w = 1'b0;
  logic [31:0] dp_a = '0, pd_a = '0;
  int          dp_i = 0, pd_i = 0;

  always @(negedge clk) begin
    if (hready && !rst) begin
      if (dp_v && dp_w && dp_i < 64) log_data[dp_i] = hwdata;
      pd_v = (htrans != 2'b00); pd_w = hwrite; pd_a = haddr; pd_i = nlog;
      if (htrans != 2'b00) begin
        if (nlog < 64) begin
          log_addr[nlog] = haddr; log_wr[nlog] = hwrite;
          log_tr[nlog] = htrans;  log_bu[nlog] = hburst;
        end
        nlog++;
      end
    end else begin
      pd_v = dp_v; pd_w = dp_w; pd_a = dp_a; pd_i = dp_i;
    end
  end

  always @(posedge clk) begin
    #1;
    dp_v = pd_v; dp_w = pd_w; dp_a = pd_a; dp_i = pd_i;
    hrdata = mem_word(pd_a);
    cyc++;
    hready = rst ? 1'b1 : !(stall != 0 && (cyc % 3) == 1);
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic wait_quiet;
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      if (htrans == 2'b00) q++; else q = 0;
    end
  endtask

  task automatic rd_beat(output logic [31:0] d);
    p_beat = 1'b1;
    #1;
    while (!p_ack) begin @(negedge clk); #1; end
    d = p_rdata;
    @(negedge clk);
    p_beat = 1'b0;
  endtask

  task automatic wr_beat(input logic [31:0] d);
    p_wdata = d;
    p_beat  = 1'b1;
    #1;
    while (!p_ack) begin @(negedge clk); #1; end
    @(negedge clk);
    p_beat = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] base, input int n);
    logic [31:0] d;
    string tag;
    tag = stall ? "R3/R8" : "R3";
    @(negedge clk);
    nlog = 0;
    p_sel = 1'b1; p_write = 1'b0; p_addr = base;
    for (int k = 0; k < n; k++) begin
      rd_beat(d);
      chk(tag, "read word", d, mem_word(base + 32'(4 * k)));
    end
    p_sel = 1'b0;
    wait_quiet();
    chk("R2", "read beat count", 32'(nlog), 32'd4);
    chk("R2", "read burst type", 32'(log_bu[0]), 32'h3);
    chk("R2", "hsize", 32'(hsize), 32'h2);
    for (int k = 0; k < 4; k++) begin
      chk("R2", "read beat addr", log_addr[k], base + 32'(4 * k));
      chk("R2", "read beat trans", 32'(log_tr[k]), (k == 0) ? 32'h2 : 32'h3);
      chk("R2", "read beat dir", 32'(log_wr[k]), 32'h0);
    end
  endtask

  task automatic do_write(input logic [31:0] base, input int n);
    string tag;
    tag = stall ? "R5/R8" : "R5";
    @(negedge clk);
    nlog = 0;
    p_sel = 1'b1; p_write = 1'b1; p_addr = base;
    for (int k = 0; k < n; k++) wr_beat(wr_word(base, k));
    chk(tag, "no AHB write before end", 32'(nlog), 32'd0);
    p_sel = 1'b0;
    wait_quiet();
    chk(tag, "write beat count", 32'(nlog), 32'(n));
    chk("R6", "write burst type", 32'(log_bu[0]), (n == 1) ? 32'h0 : 32'h1);
    for (int k = 0; k < n && k < 64; k++) begin
      chk(tag, "write beat addr", log_addr[k], base + 32'(4 * k));
      chk(tag, "write beat data", log_data[k], wr_word(base, k));
      chk(tag, "write beat trans", 32'(log_tr[k]), (k == 0) ? 32'h2 : 32'h3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int idx = 0;
    p_sel = 1'b1; p_beat = 1'b1; p_write = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "htrans in reset", 32'(htrans), 32'h0);
    chk("R9", "p_ack in reset", 32'(p_ack), 32'h0);
    p_sel = 1'b0; p_beat = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "htrans after reset", 32'(htrans), 32'h0);
    chk("R9", "p_ack after reset", 32'(p_ack), 32'h0);

    for (int s = 0; s < 2; s++) begin
      stall = s;
      for (int n = 1; n <= 4; n++) begin
        do_read(32'h0000_1000 + 32'(idx) * 32'h100, n);  // R4 via fresh data
        idx++;
      end
      for (int n = 1; n <= 16; n++) begin
        do_write(32'h0002_0000 + 32'(idx) * 32'h100, n);
        idx++;
        if (n == 3) begin
          do_read(32'h0000_8000 + 32'(idx) * 32'h10, 1);  // R4 after write
          idx++;
        end
      end
    end
    stall = 0;

    // R7: 17th beat waits while the data FIFO is full
    @(negedge clk);
    nlog = 0;
    p_sel = 1'b1; p_write = 1'b1; p_addr = 32'h0004_0000;
    for (int k = 0; k < 16; k++) wr_beat(wr_word(32'h0004_0000, k));
    p_wdata = 32'hDEAD_BEEF; p_beat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk("R7", "p_ack while full", 32'(p_ack), 32'h0);
      @(negedge clk);
    end
    p_beat = 1'b0; p_sel = 1'b0;
    wait_quiet();
    chk("R7", "capped burst length", 32'(nlog), 32'd16);
    chk("R7", "last capped word", log_data[15], wr_word(32'h0004_0000, 15));

    // R1: no grant, no transaction
    @(negedge clk);
    nlog = 0;
    p_gnt = 1'b0; p_sel = 1'b1; p_write = 1'b0; p_addr = 32'h0005_0000; p_beat = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      chk("R1", "p_ack without grant", 32'(p_ack), 32'h0);
    end
    chk("R1", "AHB beats without grant", 32'(nlog), 32'd0);
    p_beat = 1'b0; p_sel = 1'b0; p_gnt = 1'b1;
    wait_quiet();

    // R10: empty write
    @(negedge clk);
    nlog = 0;
    p_sel = 1'b1; p_write = 1'b1; p_addr = 32'h0006_0000;
    repeat (3) @(negedge clk);
    p_sel = 1'b0;
    wait_quiet();
    chk("R10", "beats for empty write", 32'(nlog), 32'd0);

    // R4: final read after partial reads returns its own words
    do_read(32'h0007_0000, 4);
    finish_run();
  end
endmodule